// File: doc/BRIEF.md
# Free-Running Timer with Edge-Triggered Capture

This block keeps a 16-bit up-counter that advances once for each cycle in which the tick enable is high. The tick enable is meant to carry a 1 MHz strobe, so one count is one microsecond. It raises two timing interrupts. A periodic pulse comes every 1024 counts, and a wrap pulse comes when the counter rolls over from its top value to zero, which is every 65536 counts. Firmware can read the counter at any time through a byte-wide register port. Reading the low byte also freezes a copy of the high byte, so the two reads form one consistent 16-bit value.

Two capture channels each watch an external pin. The pin is synchronized, and the channel then looks for a rising or a falling edge, chosen per channel. On that edge the channel stores one byte taken from the counter, at a bit offset that firmware programs, and raises its own interrupt. A gang mode joins the two channels: an edge on the first pin stores the whole counter in one clock, with the low byte in the first register and the high byte in the second. Only the first channel interrupts in this mode.

Top module: `frt_capture`

## Requirements
- R1: After reset the counter, both capture registers, the control register, the second window field and the read data are zero, and all interrupt outputs are low.
- R2: The counter adds one in each clock with `tick_en` high, holds its value otherwise, and wraps from 0xFFFF to 0x0000.
- R3: `irq_tick` is high for exactly one cycle, the cycle in which a tick has just made the low 10 counter bits zero.
- R4: `irq_wrap` is high for exactly one cycle, the cycle in which a tick has just moved the counter from 0xFFFF to 0x0000. It coincides with `irq_tick`.
- R5: A read (`rd_en` high) returns data on `rdata` one clock later. The address map is: 0 the counter low byte (this read also freezes the high byte), 1 the frozen high byte, 2 capture register A, 3 capture register B, 4 control, 5 window B. Any other address reads zero.
- R6: Control register (address 4): bit 0 sets falling edge on pin A, bit 1 sets falling edge on pin B, bit 2 turns on gang mode, and bits 7:4 hold window A. Bit 3 always reads 0. Address 5 holds window B in bits 3:0. A write takes effect from the next clock.
- R7: Each pin passes through two synchronizer flops. The capture register and a one-cycle pulse on its `irq_cap` bit (bit 0 for A, bit 1 for B) appear three clocks after the pin changes. The stored value comes from the counter as it stood in the cycle the edge was detected, that is, the count two ticks after the pin change while ticking.
- R8: With window value s, the captured byte is counter[s+7:s]. A value above 8 is treated as 8.
- R9: An edge of the unselected polarity stores nothing and raises no interrupt.
- R10: In gang mode an edge on pin A stores counter[7:0] in A and counter[15:8] in B and pulses only `irq_cap[0]`. Pin B is ignored in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe, one count per high cycle |
| cap_in_a | input | 1 | Capture pin A (asynchronous) |
| cap_in_b | input | 1 | Capture pin B (asynchronous) |
| addr | input | 3 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq_tick | output | 1 | Periodic pulse every 1024 counts |
| irq_wrap | output | 1 | Counter overflow pulse |
| irq_cap | output | 2 | Capture pulses, bit 0 channel A, bit 1 channel B |

## Verification
The capture path is driven with a frozen counter under window offsets 0, 3, a clamped 12, and 5 on the second channel. Each case produces a different byte, so a wrong shift or a missing clamp shows up. Edges of both polarities are applied under each polarity setting, which separates a correct edge select from a level trigger or an inverted select. One capture is taken while the counter is running, which pins down the exact cycle whose count is stored. The gang test first toggles pin B and then pin A at a count whose two bytes differ from the windowed results. Long tick runs cross several 1024 boundaries and the full wrap, and they compare the number of pulses on each interrupt.

// File: rtl/frt_pkg.sv
package frt_pkg;

  typedef enum logic [2:0] {
    ADR_CNT_LO  = 3'd0,
    ADR_CNT_SNP = 3'd1,
    ADR_CAP_A   = 3'd2,
    ADR_CAP_B   = 3'd3,
    ADR_CTRL    = 3'd4,
    ADR_WIN_B   = 3'd5
  } frt_addr_e;

  localparam int CTRL_POL_A = 0;
  localparam int CTRL_POL_B = 1;
  localparam int CTRL_GANG  = 2;
  localparam int CTRL_WIN_A = 4;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int CNT_W     = 16,
  parameter int TICK_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt,
  output logic             irq_tick,
  output logic             irq_wrap
);

  localparam logic [CNT_W-1:0]     ONE      = 1;
  localparam logic [TICK_LOG2-1:0] PER_LAST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      tick_q <= tick_en && (cnt_q[TICK_LOG2-1:0] == PER_LAST);
      wrap_q <= tick_en && (&cnt_q);
      if (tick_en) begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign cnt      = cnt_q;
  assign irq_tick = tick_q;
  assign irq_wrap = wrap_q;

endmodule

// File: rtl/frt_edge_det.sv
module frt_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl = sync_q[STAGES-1];

  always_comb begin
    if (fall_sel) begin
      evt = prev_q & ~lvl;
    end else begin
      evt = ~prev_q & lvl;
    end
  end

endmodule

// File: rtl/frt_cap_unit.sv
module frt_cap_unit #(
  parameter int CNT_W = 16,
  parameter int CAP_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       evt,
  input  logic             gang,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  output logic [CAP_W-1:0] cap_a,
  output logic [CAP_W-1:0] cap_b,
  output logic [1:0]       irq
);

  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(CNT_W - CAP_W);

  function automatic logic [CAP_W-1:0] window(input logic [CNT_W-1:0] c,
                                              input logic [SEL_W-1:0] s);
    logic [SEL_W-1:0] eff;
    eff = (s > MAX_SEL) ? MAX_SEL : s;
    return CAP_W'(c >> eff);
  endfunction

  logic [CAP_W-1:0] win_a;
  logic [CAP_W-1:0] win_b;
  logic [CAP_W-1:0] gang_hi;

  assign win_a   = window(cnt, sel_a);
  assign win_b   = window(cnt, sel_b);
  assign gang_hi = CAP_W'(cnt >> CAP_W);

  logic [CAP_W-1:0] cap_a_q;
  logic [CAP_W-1:0] cap_b_q;
  logic [1:0]       irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a_q <= '0;
      cap_b_q <= '0;
      irq_q   <= '0;
    end else begin
      irq_q <= '0;
      if (gang) begin
        if (evt[0]) begin
          cap_a_q  <= cnt[CAP_W-1:0];
          cap_b_q  <= gang_hi;
          irq_q[0] <= 1'b1;
        end
      end else begin
        if (evt[0]) begin
          cap_a_q  <= win_a;
          irq_q[0] <= 1'b1;
        end
        if (evt[1]) begin
          cap_b_q  <= win_b;
          irq_q[1] <= 1'b1;
        end
      end
    end
  end

  assign cap_a = cap_a_q;
  assign cap_b = cap_b_q;
  assign irq   = irq_q;

endmodule

// File: rtl/frt_regs.sv
module frt_regs
  import frt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CAP_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic [CAP_W-1:0] wdata,
  input  logic             rd_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CAP_W-1:0] cap_a,
  input  logic [CAP_W-1:0] cap_b,
  output logic [1:0]       pol,
  output logic             gang,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b,
  output logic [CAP_W-1:0] rdata
);

  localparam int HI_W = CNT_W - CAP_W;

  function automatic logic [CAP_W-1:0] ctrl_mask();
    logic [CAP_W-1:0] m;
    m = '0;
    m[CTRL_POL_A] = 1'b1;
    m[CTRL_POL_B] = 1'b1;
    m[CTRL_GANG]  = 1'b1;
    for (int i = 0; i < SEL_W; i++) begin
      m[CTRL_WIN_A + i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [CAP_W-1:0] CTRL_MASK = ctrl_mask();

  logic [CAP_W-1:0] ctrl_q;
  logic [SEL_W-1:0] win_b_q;
  logic [HI_W-1:0]  snap_q;
  logic [CAP_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      win_b_q <= '0;
    end else if (wr_en) begin
      if (addr == ADR_CTRL) begin
        ctrl_q <= wdata & CTRL_MASK;
      end
      if (addr == ADR_WIN_B) begin
        win_b_q <= wdata[SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else if (rd_en) begin
      case (addr)
        ADR_CNT_LO: begin
          rdata_q <= cnt[CAP_W-1:0];
          snap_q  <= cnt[CNT_W-1:CAP_W];
        end
        ADR_CNT_SNP: rdata_q <= CAP_W'(snap_q);
        ADR_CAP_A:   rdata_q <= cap_a;
        ADR_CAP_B:   rdata_q <= cap_b;
        ADR_CTRL:    rdata_q <= ctrl_q;
        ADR_WIN_B:   rdata_q <= CAP_W'(win_b_q);
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign pol   = {ctrl_q[CTRL_POL_B], ctrl_q[CTRL_POL_A]};
  assign gang  = ctrl_q[CTRL_GANG];
  assign sel_a = ctrl_q[CTRL_WIN_A +: SEL_W];
  assign sel_b = win_b_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/frt_capture.sv
module frt_capture
  import frt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CAP_W       = 8,
  parameter int TICK_LOG2   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cap_in_a,
  input  logic             cap_in_b,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic [CAP_W-1:0] wdata,
  input  logic             rd_en,
  output logic [CAP_W-1:0] rdata,
  output logic             irq_tick,
  output logic             irq_wrap,
  output logic [1:0]       irq_cap
);

  localparam int SEL_W = $clog2(CNT_W - CAP_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CAP_W-1:0]  cap_a_q;
  logic [CAP_W-1:0]  cap_b_q;
  logic [1:0]        pol;
  logic              gang_q;
  logic [SEL_W-1:0]  sel_a;
  logic [SEL_W-1:0]  sel_b;
  logic [NUM_CH-1:0] pins;
  logic [NUM_CH-1:0] evt;

  assign pins = {cap_in_b, cap_in_a};

  frt_counter #(
    .CNT_W     (CNT_W),
    .TICK_LOG2 (TICK_LOG2)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .cnt      (cnt_q),
    .irq_tick (irq_tick),
    .irq_wrap (irq_wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    frt_edge_det #(
      .STAGES (SYNC_STAGES)
    ) u_edge (
      .clk      (clk),
      .rst      (rst),
      .pin      (pins[g]),
      .fall_sel (pol[g]),
      .evt      (evt[g])
    );
  end

  frt_cap_unit #(
    .CNT_W (CNT_W),
    .CAP_W (CAP_W),
    .SEL_W (SEL_W)
  ) u_cap (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt_q),
    .evt   (evt),
    .gang  (gang_q),
    .sel_a (sel_a),
    .sel_b (sel_b),
    .cap_a (cap_a_q),
    .cap_b (cap_b_q),
    .irq   (irq_cap)
  );

  frt_regs #(
    .CNT_W (CNT_W),
    .CAP_W (CAP_W),
    .SEL_W (SEL_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .wr_en (wr_en),
    .wdata (wdata),
    .rd_en (rd_en),
    .cnt   (cnt_q),
    .cap_a (cap_a_q),
    .cap_b (cap_b_q),
    .pol   (pol),
    .gang  (gang_q),
    .sel_a (sel_a),
    .sel_b (sel_b),
    .rdata (rdata)
  );

endmodule

// File: rtl/frt_capture_chk.sv
module frt_capture_chk #(
  parameter int CNT_W     = 16,
  parameter int CAP_W     = 8,
  parameter int TICK_LOG2 = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic [CNT_W-1:0] cnt,
  input logic             irq_tick,
  input logic             irq_wrap,
  input logic [1:0]       irq_cap,
  input logic [CAP_W-1:0] cap_a,
  input logic [CAP_W-1:0] cap_b,
  input logic             gang
);

  localparam logic [CNT_W-1:0] ONE = 1;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !irq_tick && !irq_wrap && irq_cap == 2'b00));

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> cnt == $past(cnt) + ONE);

  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt));

  a_r3_tick_boundary: assert property (@(posedge clk) disable iff (rst)
    irq_tick |-> (cnt[TICK_LOG2-1:0] == '0 && $past(tick_en)));

  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    irq_wrap |-> (cnt == '0 && irq_tick));

  a_r7_cap_a_quiet: assert property (@(posedge clk) disable iff (rst)
    !irq_cap[0] |-> $stable(cap_a));

  a_r7_cap_b_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_cap == 2'b00) |-> $stable(cap_b));

  a_r10_gang_no_b_irq: assert property (@(posedge clk) disable iff (rst)
    irq_cap[1] |-> !$past(gang));

endmodule

bind frt_capture frt_capture_chk #(
  .CNT_W     (CNT_W),
  .CAP_W     (CAP_W),
  .TICK_LOG2 (TICK_LOG2)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .cnt      (cnt_q),
  .irq_tick (irq_tick),
  .irq_wrap (irq_wrap),
  .irq_cap  (irq_cap),
  .cap_a    (cap_a_q),
  .cap_b    (cap_b_q),
  .gang     (gang_q)
);

// File: tb/test_frt_capture.sv
module test_frt_capture;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       pin_a = 1'b0;
  logic       pin_b = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq_tick;
  logic       irq_wrap;
  logic [1:0] irq_cap;

  int errs = 0;
  int checks = 0;
  int exp_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  frt_capture i_frt_capture (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .cap_in_a (pin_a),
    .cap_in_b (pin_b),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .irq_tick (irq_tick),
    .irq_wrap (irq_wrap),
    .irq_cap  (irq_cap)
  );

  function automatic int win(int c, int s);
    int e;
    e = (s > 8) ? 8 : s;
    return (c >> e) & 255;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    addr = a;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(int n);
    int et = 0, ew = 0, ot = 0, ow = 0;
    @(negedge clk);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      if ((exp_cnt & 1023) == 1023) et++;
      if (exp_cnt == 65535) ew++;
      exp_cnt = (exp_cnt + 1) & 65535;
      @(negedge clk);
      if (i == n - 1) tick_en = 1'b0;
      ot += int'(irq_tick);
      ow += int'(irq_wrap);
    end
    @(negedge clk);
    ot += int'(irq_tick);
    ow += int'(irq_wrap);
    chk("R3", "periodic pulse count", ot, et);
    chk("R4", "wrap pulse count", ow, ew);
  endtask

  task automatic drive_pin(int ch, logic lvl, output int n0, output int n1);
    @(negedge clk);
    if (ch == 0) pin_a = lvl;
    else pin_b = lvl;
    n0 = 0;
    n1 = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      n0 += int'(irq_cap[0]);
      n1 += int'(irq_cap[1]);
    end
  endtask

  task automatic t_reset;
    int v;
    chk("R1", "irq_tick", int'(irq_tick), 0);
    chk("R1", "irq_wrap", int'(irq_wrap), 0);
    chk("R1", "irq_cap", int'(irq_cap), 0);
    chk("R1", "rdata", int'(rdata), 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1", $sformatf("reg %0d", a), v, 0);
    end
  endtask

  task automatic t_ctrl_rw;
    int v;
    wr(3'd4, 8'hFF);
    rd(3'd4, v);
    chk("R6", "ctrl reserved bit 3 masked", v, 8'hF7);
    wr(3'd5, 8'hA9);
    rd(3'd5, v);
    chk("R6", "window B keeps bits 3:0", v, 8'h09);
    rd(3'd7, v);
    chk("R5", "unmapped address", v, 0);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_count_read;
    int v;
    run_ticks(300);
    rd(3'd0, v);
    chk("R5", "count low byte", v, exp_cnt & 255);
    rd(3'd1, v);
    chk("R5", "frozen high byte", v, exp_cnt >> 8);
    run_ticks(256);
    rd(3'd1, v);
    chk("R5", "high byte stays frozen", v, 1);
    rd(3'd0, v);
    chk("R2", "count low after more ticks", v, exp_cnt & 255);
    rd(3'd1, v);
    chk("R2", "count high after more ticks", v, exp_cnt >> 8);
  endtask

  task automatic t_periodic;
    int v;
    run_ticks(2000);
    rd(3'd0, v);
    chk("R2", "count low", v, exp_cnt & 255);
    rd(3'd1, v);
    chk("R2", "count high", v, exp_cnt >> 8);
  endtask

  task automatic t_cap_polarity;
    int n0, n1, v;
    drive_pin(0, 1'b1, n0, n1);
    chk("R7", "rising capture irq A", n0, 1);
    chk("R7", "no irq B", n1, 0);
    rd(3'd2, v);
    chk("R7", "capture A window 0", v, win(exp_cnt, 0));
    drive_pin(0, 1'b0, n0, n1);
    chk("R9", "falling edge ignored in rising mode", n0, 0);
    wr(3'd4, 8'h31);
    drive_pin(0, 1'b1, n0, n1);
    chk("R9", "rising edge ignored in falling mode", n0, 0);
    rd(3'd2, v);
    chk("R9", "capture A unchanged", v, win(exp_cnt, 0));
    drive_pin(0, 1'b0, n0, n1);
    chk("R9", "falling capture irq A", n0, 1);
    rd(3'd2, v);
    chk("R8", "capture A window 3", v, win(exp_cnt, 3));
  endtask

  task automatic t_cap_clamp;
    int n0, n1, v;
    wr(3'd4, 8'hC0);
    drive_pin(0, 1'b1, n0, n1);
    chk("R8", "irq for window 12", n0, 1);
    rd(3'd2, v);
    chk("R8", "window 12 clamps to 8", v, win(exp_cnt, 8));
    drive_pin(0, 1'b0, n0, n1);
  endtask

  task automatic t_cap_b;
    int n0, n1, v, keep_a;
    rd(3'd2, keep_a);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h05);
    drive_pin(1, 1'b1, n0, n1);
    chk("R7", "irq B once", n1, 1);
    chk("R7", "no irq A on pin B", n0, 0);
    rd(3'd3, v);
    chk("R8", "capture B window 5", v, win(exp_cnt, 5));
    rd(3'd2, v);
    chk("R7", "capture A untouched by pin B", v, keep_a);
    drive_pin(1, 1'b0, n0, n1);
  endtask

  task automatic t_cap_running;
    int n0 = 0, c0, v;
    wr(3'd4, 8'h00);
    @(negedge clk);
    c0 = exp_cnt;
    tick_en = 1'b1;
    pin_a = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      n0 += int'(irq_cap[0]);
    end
    tick_en = 1'b0;
    exp_cnt = (exp_cnt + 6) & 65535;
    chk("R7", "irq while counting", n0, 1);
    rd(3'd2, v);
    chk("R7", "count of detection cycle", v, win(c0 + 2, 0));
    drive_pin(0, 1'b0, n0, v);
  endtask

  task automatic t_gang;
    int n0, n1, v, keep_b;
    run_ticks(291);
    rd(3'd3, keep_b);
    wr(3'd4, 8'h04);
    drive_pin(1, 1'b1, n0, n1);
    chk("R10", "pin B ignored irq", n0 + n1, 0);
    rd(3'd3, v);
    chk("R10", "capture B unchanged by pin B", v, keep_b);
    drive_pin(0, 1'b1, n0, n1);
    chk("R10", "gang irq A once", n0, 1);
    chk("R10", "gang no irq B", n1, 0);
    rd(3'd2, v);
    chk("R10", "gang low byte", v, exp_cnt & 255);
    rd(3'd3, v);
    chk("R10", "gang high byte", v, exp_cnt >> 8);
    drive_pin(0, 1'b0, n0, n1);
    drive_pin(1, 1'b0, n0, n1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_wrap;
    int v;
    run_ticks(65536 - exp_cnt);
    rd(3'd0, v);
    chk("R2", "wrapped low", v, 0);
    rd(3'd1, v);
    chk("R2", "wrapped high", v, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_count_read();
    t_periodic();
    t_cap_polarity();
    t_cap_clamp();
    t_cap_b();
    t_cap_running();
    t_gang();
    t_wrap();
    finished = 1;
    summary();
  end

endmodule